// File: doc/BRIEF.md
# Two-Wire Slave 16-bit Register Bridge

This block is a slave on a two-wire serial bus (SCL and SDA, I2C-style). It gives a bus master read and write access to a bank of 16-bit registers. An 8-bit register pointer selects the register. Both bus lines are oversampled in the system clock domain and pass through synchronisers. The slave never drives SCL. It pulls SDA low through an open-drain enable, and it changes that enable only while SCL is low.

A write transaction works as follows:

1. The master addresses the device with the direction bit cleared.
2. The first byte after the address sets the pointer.
3. The data bytes that follow arrive high byte first, and each pair forms one register word.

A read transaction first sets the pointer in the same way. The master then sends a repeated start with the read address, and the slave streams register bytes, high byte first. The pointer steps by one after every complete word, whether the word was written or read.

Byte-wide access uses a separate low-byte port at pointer value 0x80:

- **Byte-wide write:** a lone high byte sent to a register is held pending together with its address. A later byte written to 0x80 commits the pair to the held address.
- **Byte-wide read:** reading the high byte of a register copies its low byte into the 0x80 port, where the master can read it.

Top module: `twi_regbank16`

## Requirements
- R1: After reset `sda_oe_o` is 0, and the slave pulls SDA low only in an acknowledge slot that it owns or while it sends read data.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bus bits sent with no start condition before them are not acknowledged.
- R3: The first byte after a start is the 7-bit device address, MSB first, followed by a direction bit in bit 0 (0 = write, 1 = read). A matching address is acknowledged by SDA low during the ninth clock.
- R4: A non-matching address is not acknowledged. The slave then keeps SDA released and writes nothing until the next start or stop.
- R5: In a write, the first byte after the address loads the pointer. The following bytes are data, high byte first. Every received byte is acknowledged, and each pair of bytes writes one 16-bit register at the pointer.
- R6: The pointer increases by one after each complete two-byte word, written or read.
- R7: After a repeated start with the read address, the slave sends the word at the pointer, high byte then low byte, MSB first. A master acknowledge continues the read. A not-acknowledge ends it, and SDA stays released.
- R8: The SDA drive enable changes only while SCL is low.
- R9: A start or stop that arrives before a word is complete discards the partial word, so the target register keeps its old value.
- R10: A lone high byte written to a register is held with that register's address. A byte written at pointer 0x80 commits {held high byte, new byte} to the held address and clears the held byte. A byte written at 0x80 with nothing held has no effect, and the pointer does not move while it is 0x80.
- R11: Reading the high byte of a register copies its low byte into the 0x80 port. Reads at pointer 0x80 return that copied byte, and the pointer does not move.
- R12: Pointer values at or above the register count (other than 0x80) are acknowledged, ignore writes and read as 0x0000.
- R13: All registers read 0x0000 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The main transfer is exercised with:

- A six-byte burst written and then read back as one stream. This separates correct high-then-low byte order and per-word pointer stepping from per-byte stepping.
- A foreign device address, and address bits sent with no start. These show whether the slave ever acknowledges when it should stay silent.
- A lone high byte followed by a low-port byte. This checks the pending-commit path, and reading the register before the commit shows that the partial word was not stored.
- A start injected halfway through a byte, and accesses above the register count. These separate abort handling from pointer persistence, and real storage from the zero-read region.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start
      ST_RXB,    // shifting in a byte (address or data)
      ST_ACK,    // slave holds acknowledge slot
      ST_TXB,    // shifting out a read byte
      ST_MACK,   // master acknowledge slot
      ST_SKIP    // not addressed, wait for start/stop
   } twi_state_e;

   localparam int BYTE_W = 8;
   localparam int PTR_W  = 8;
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_d, sda_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_ff[g-1];
               sda_ff[g] <= sda_ff[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_ff[STAGES-1];
         sda_d <= sda_ff[STAGES-1];
      end
   end

   assign scl_o   = scl_ff[STAGES-1];
   assign sda_o   = sda_ff[STAGES-1];
   assign start_o = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
   assign rise_o  = scl_o & ~scl_d;
   assign fall_o  = ~scl_o & scl_d;
endmodule

// File: rtl/twi_byte_engine.sv
`timescale 1ns/1ps
module twi_byte_engine
   import twi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h5D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s_i,
   input  logic              sda_s_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              ptr_stb_o,
   output logic              data_stb_o,
   output logic              rd_stb_o,
   output logic              abort_o
);
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   twi_state_e        state;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic              addr_phase, rd_dir, first_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         addr_phase <= 1'b0;
         rd_dir     <= 1'b0;
         first_data <= 1'b0;
         sda_oe_o   <= 1'b0;
         rx_byte_o  <= '0;
         ptr_stb_o  <= 1'b0;
         data_stb_o <= 1'b0;
         rd_stb_o   <= 1'b0;
         abort_o    <= 1'b0;
      end else begin
         ptr_stb_o  <= 1'b0;
         data_stb_o <= 1'b0;
         rd_stb_o   <= 1'b0;
         abort_o    <= 1'b0;
         if (start_i) begin
            state      <= ST_RXB;
            addr_phase <= 1'b1;
            cnt        <= '0;
            sda_oe_o   <= 1'b0;
            abort_o    <= 1'b1;
         end else if (stop_i) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            abort_o  <= 1'b1;
         end else begin
            unique case (state)
               ST_RXB: begin
                  if (rise_i && cnt < LAST_BIT) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s_i};
                     cnt <= cnt + 4'd1;
                  end
                  if (fall_i && cnt == LAST_BIT) begin
                     if (addr_phase) begin
                        addr_phase <= 1'b0;
                        if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                           sda_oe_o   <= 1'b1;
                           rd_dir     <= sh[0];
                           first_data <= 1'b1;
                           state      <= ST_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        sda_oe_o  <= 1'b1;
                        rx_byte_o <= sh;
                        state     <= ST_ACK;
                        if (first_data) begin
                           ptr_stb_o  <= 1'b1;
                           first_data <= 1'b0;
                        end else begin
                           data_stb_o <= 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (fall_i) begin
                     cnt <= '0;
                     if (rd_dir) begin
                        sh       <= tx_byte_i;
                        sda_oe_o <= ~tx_byte_i[BYTE_W-1];
                        state    <= ST_TXB;
                     end else begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_RXB;
                     end
                  end
               end
               ST_TXB: begin
                  if (rise_i) cnt <= cnt + 4'd1;
                  if (fall_i) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_MACK;
                     end else begin
                        sh       <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe_o <= ~sh[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (rise_i) begin
                     rd_stb_o <= 1'b1;
                     if (sda_s_i) state <= ST_SKIP;
                  end
                  if (fall_i) begin
                     cnt      <= '0;
                     sh       <= tx_byte_i;
                     sda_oe_o <= ~tx_byte_i[BYTE_W-1];
                     state    <= ST_TXB;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_s_i);                                    // R8
   AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_BIT);                                                     // R3
   AST_QUIET_WHEN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && $past(state) == ST_SKIP) |-> !sda_oe_o);         // R4
endmodule

// File: rtl/twi_word_bank.sv
`timescale 1ns/1ps
module twi_word_bank
   import twi_pkg::*;
#(
   parameter int NUM_REGS   = 16,
   parameter int DATA_W     = 16,
   parameter int LOW_PORT   = 128,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              ptr_stb_i,
   input  logic              data_stb_i,
   input  logic              rd_stb_i,
   input  logic              abort_i,
   output logic [BYTE_W-1:0] tx_byte_o
);
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam logic [PTR_W-1:0] LOW_PTR = PTR_W'(LOW_PORT);

   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("twi_word_bank: DATA_W must be two bytes");
   end
   if (NUM_REGS < 2 || NUM_REGS > LOW_PORT) begin : g_bad_depth
      $error("twi_word_bank: NUM_REGS must lie between 2 and LOW_PORT");
   end

   logic [DATA_W-1:0] regs [NUM_REGS];
   logic [PTR_W-1:0]  ptr, pend_a;
   logic              phase, pend_v;
   logic [BYTE_W-1:0] hi_buf, lo_port;
   logic              in_range, pend_in, at_low, wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] cur_word, wr_val;

   assign in_range = int'(ptr) < NUM_REGS;
   assign pend_in  = int'(pend_a) < NUM_REGS;
   assign at_low   = (ptr == LOW_PTR);
   assign cur_word = in_range ? regs[ptr[IDX_W-1:0]] : '0;
   assign tx_byte_o = at_low ? lo_port :
                      (phase ? cur_word[BYTE_W-1:0] : cur_word[DATA_W-1:BYTE_W]);

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = ptr[IDX_W-1:0];
      wr_val = {hi_buf, rx_byte_i};
      if (data_stb_i) begin
         if (at_low) begin
            if (pend_v && pend_in) begin
               wr_en  = 1'b1;
               wr_idx = pend_a[IDX_W-1:0];
            end
         end else if (phase && in_range) begin
            wr_en = 1'b1;
         end
      end
   end

   if (RESET_REGS) begin : g_rst_store
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
         end else if (wr_en) begin
            regs[wr_idx] <= wr_val;
         end
      end
   end else begin : g_plain_store
      always_ff @(posedge clk) begin
         if (wr_en) regs[wr_idx] <= wr_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         phase   <= 1'b0;
         hi_buf  <= '0;
         pend_v  <= 1'b0;
         pend_a  <= '0;
         lo_port <= '0;
      end else if (abort_i) begin
         phase <= 1'b0;
      end else if (ptr_stb_i) begin
         ptr   <= rx_byte_i;
         phase <= 1'b0;
      end else if (data_stb_i) begin
         if (at_low) begin
            pend_v <= 1'b0;
         end else if (!phase) begin
            hi_buf <= rx_byte_i;
            pend_v <= 1'b1;
            pend_a <= ptr;
            phase  <= 1'b1;
         end else begin
            phase  <= 1'b0;
            ptr    <= ptr + 1'b1;
            pend_v <= 1'b0;
         end
      end else if (rd_stb_i && !at_low) begin
         if (!phase) begin
            lo_port <= cur_word[BYTE_W-1:0];
            phase   <= 1'b1;
         end else begin
            phase <= 1'b0;
            ptr   <= ptr + 1'b1;
         end
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ptr_stb_i) && !$stable(ptr)) |-> ptr == $past(ptr) + 1'b1);   // R6
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ptr_stb_i, data_stb_i, rd_stb_i, abort_i}));               // R5
   AST_LOW_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(data_stb_i || rd_stb_i) && $past(ptr) == LOW_PTR) |-> ptr == LOW_PTR); // R10
endmodule

// File: rtl/twi_regbank16.sv
`timescale 1ns/1ps
module twi_regbank16
   import twi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h5D,
   parameter int         NUM_REGS    = 16,
   parameter int         LOW_PORT    = 128,
   parameter int         SYNC_STAGES = 2,
   parameter bit         RESET_REGS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);
   localparam int WORD_W = 2 * BYTE_W;

   if (LOW_PORT < 1 || LOW_PORT > 255) begin : g_bad_port
      $error("twi_regbank16: LOW_PORT must fit the 8-bit pointer");
   end

   logic scl_s, sda_s, start_e, stop_e, rise_e, fall_e;
   logic [BYTE_W-1:0] rx_byte, tx_byte;
   logic ptr_stb, data_stb, rd_stb, abort;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .start_o(start_e), .stop_o(stop_e),
      .rise_o(rise_e), .fall_o(fall_e)
   );

   twi_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
      .start_i(start_e), .stop_i(stop_e), .rise_i(rise_e), .fall_i(fall_e),
      .tx_byte_i(tx_byte), .sda_oe_o(sda_oe_o), .rx_byte_o(rx_byte),
      .ptr_stb_o(ptr_stb), .data_stb_o(data_stb), .rd_stb_o(rd_stb),
      .abort_o(abort)
   );

   twi_word_bank #(
      .NUM_REGS(NUM_REGS), .DATA_W(WORD_W), .LOW_PORT(LOW_PORT),
      .RESET_REGS(RESET_REGS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .rx_byte_i(rx_byte), .ptr_stb_i(ptr_stb),
      .data_stb_i(data_stb), .rd_stb_i(rd_stb), .abort_i(abort),
      .tx_byte_o(tx_byte)
   );
endmodule

// File: tb/twi_regbank16_test.sv
`timescale 1ns/1ps
module twi_regbank16_test;
   localparam logic [6:0] DEV = 7'h5D;
   localparam int N = 16;
   localparam int Q = 8;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   always #2.5 clk = ~clk;

   twi_regbank16 uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe));

   int total = 0, bad = 0;
   logic may_drive = 1'b0, prev_oe = 1'b0, done = 1'b0;
   int drive_viol = 0, edge_viol = 0;

   // behavioural reference state
   logic [15:0] mem [256];
   int m_ptr = 0, m_phase = 0, m_pend_v = 0, m_pend_a = 0;
   logic [7:0] m_hi = 0, m_lo = 0;

   // per-clock comparison of drive permission and edge placement
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe && !may_drive) drive_viol++;
         if (sda_oe !== prev_oe && scl) edge_viol++;
         prev_oe = sda_oe;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl = 1'b1; may_drive = 1'b0; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl = 1'b0; tick(Q);
      m_phase = 0;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl = 1'b1; may_drive = 1'b0; tick(Q);
      sda_m = 1'b1; tick(Q);
      m_phase = 0;
   endtask

   task automatic send_bit(input logic b, input logic nxt);
      sda_m = b; tick(Q);
      scl = 1'b1; may_drive = 1'b0; tick(2 * Q);
      if (nxt) may_drive = 1'b1;
      scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      may_drive = 1'b1; sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, input string req, input int exp_ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i], i == 0);
      recv_bit(a);
      check(req, int'(!a), exp_ack);
   endtask

   task automatic get_byte(input string req, input logic [7:0] expv, input logic ack);
      logic b;
      logic [7:0] v = 8'h00;
      for (int i = 0; i < 8; i++) begin
         recv_bit(b);
         v = {v[6:0], b};
      end
      check(req, v, expv);
      send_bit(!ack, ack);
   endtask

   task automatic m_wr(input logic [7:0] b);
      if (m_ptr == 8'h80) begin
         if (m_pend_v != 0 && m_pend_a < N) mem[m_pend_a] = {m_hi, b};
         m_pend_v = 0;
      end else if (m_phase == 0) begin
         m_hi = b; m_pend_v = 1; m_pend_a = m_ptr; m_phase = 1;
      end else begin
         if (m_ptr < N) mem[m_ptr] = {m_hi, b};
         m_ptr = (m_ptr + 1) & 255; m_phase = 0; m_pend_v = 0;
      end
   endtask

   function automatic logic [7:0] m_rd();
      logic [15:0] w = (m_ptr < N) ? mem[m_ptr] : 16'h0000;
      if (m_ptr == 8'h80) return m_lo;
      if (m_phase == 0) begin
         m_lo = w[7:0]; m_phase = 1; return w[15:8];
      end
      m_phase = 0; m_ptr = (m_ptr + 1) & 255;
      return w[7:0];
   endfunction

   task automatic set_ptr(input logic [7:0] p);
      put_byte(p, "R5", 1);
      m_ptr = p; m_phase = 0;
   endtask

   task automatic wr_regs(input logic [7:0] p, input logic [7:0] d [$], input string req);
      bus_start();
      put_byte({DEV, 1'b0}, "R3", 1);
      set_ptr(p);
      foreach (d[i]) begin
         put_byte(d[i], req, 1);
         m_wr(d[i]);
      end
      bus_stop();
   endtask

   task automatic rd_regs(input logic [7:0] p, input int n, input string req);
      bus_start();
      put_byte({DEV, 1'b0}, "R3", 1);
      set_ptr(p);
      bus_start();
      put_byte({DEV, 1'b1}, "R3", 1);
      for (int i = 0; i < n; i++) get_byte(req, m_rd(), i < n - 1);
      tick(2);
      check("R7", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      tick(5);
      rst_n = 1'b1;
      tick(4);
      check("R1", sda_oe, 0);

      rd_regs(8'd9, 2, "R13");                                // reset contents
      wr_regs(8'd2, '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC}, "R5");
      rd_regs(8'd2, 6, "R6");                                 // burst, word stepping, R7 order

      bus_start();                                            // foreign device
      put_byte({7'h22, 1'b0}, "R4", 0);
      put_byte(8'h02, "R4", 0);
      put_byte(8'hFF, "R4", 0);
      bus_stop();
      rd_regs(8'd2, 2, "R4");

      put_byte({DEV, 1'b0}, "R2", 0);                         // no start condition
      bus_stop();

      wr_regs(8'd5, '{8'hAA}, "R9");                          // lone high byte
      rd_regs(8'd5, 2, "R9");
      wr_regs(8'h80, '{8'hBB}, "R10");                        // commit to reg 5
      rd_regs(8'd5, 2, "R10");
      wr_regs(8'h80, '{8'hCC}, "R10");                        // nothing held
      rd_regs(8'd5, 2, "R10");

      bus_start();                                            // start mid-byte
      put_byte({DEV, 1'b0}, "R3", 1);
      set_ptr(8'd7);
      put_byte(8'h11, "R5", 1);
      m_wr(8'h11);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
      bus_start();
      put_byte({DEV, 1'b1}, "R3", 1);
      get_byte("R9", m_rd(), 1'b1);
      get_byte("R9", m_rd(), 1'b0);
      bus_stop();

      rd_regs(8'd2, 1, "R11");                                // high byte only
      rd_regs(8'h80, 2, "R11");                               // low port, no step

      wr_regs(8'h20, '{8'hDE, 8'hAD}, "R12");
      rd_regs(8'h20, 2, "R12");
      rd_regs(8'd3, 2, "R12");                                // neighbours intact

      check("R1", drive_viol, 0);
      check("R8", edge_viol, 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule